// File: doc/BRIEF.md
# Two-wire bus condition detector

This block is the front end of a two-wire serial slave that runs from a fast system clock. It takes the raw clock and data lines of the bus and brings each one into the clock domain. It then removes short glitches from each line and turns the cleaned lines into single-cycle strobes. The strobes mark a start condition, a stop condition, a clock rising edge and a clock falling edge. A rising-edge strobe also carries the data bit captured on that edge.

The byte-level protocol engine sits behind it and consumes the strobes. An enable input lets that engine make the detector blind to the bus, for example while an internal programming cycle runs. The glitch limit is the parameter `FILTER_CYCLES`, counted in system clocks. At 50 MHz the default of 5 rejects pulses shorter than 100 ns.

Top module: `tw_cond_detect`

## Requirements
- R1: While rst_ni is low and after it is released, with both lines idle high, all strobes (start_o, stop_o, scl_rise_o, scl_fall_o) are 0 and bit_o is 0.
- R2: A fall of the filtered data line while the filtered clock line is high in both the previous and the current cycle produces start_o high for exactly one clock.
- R3: A rise of the filtered data line while the filtered clock line is high in both the previous and the current cycle produces stop_o high for exactly one clock.
- R4: A rise of the filtered clock line produces scl_rise_o for one clock. In that same cycle bit_o takes the filtered data level (1 = line high), and bit_o holds that value until the next clock rise.
- R5: A fall of the filtered clock line produces scl_fall_o for one clock.
- R6: A raw level that holds for fewer than FILTER_CYCLES consecutive system clocks is ignored. A level that holds for exactly FILTER_CYCLES clocks is accepted. The strobe for an accepted change is high in the cycle after the (FILTER_CYCLES+3)th rising clock edge that samples the new raw level.
- R7: While en_i is low, no strobe is produced, and filtering keeps tracking both lines. Changes that happened while disabled produce no strobe when en_i returns high.
- R8: Data-line changes while the filtered clock line is low never produce start_o or stop_o.
- R9: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detection enable; low ignores the bus |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| start_o | output | 1 | Start condition strobe |
| stop_o | output | 1 | Stop condition strobe |
| scl_rise_o | output | 1 | Clock rising-edge strobe |
| scl_fall_o | output | 1 | Clock falling-edge strobe |
| bit_o | output | 1 | Data bit captured at the last clock rise |

## Verification
The assertions assume the raw lines stay valid around reset. They also assume the two filtered lines never change in the same cycle without a settled clock level on either side. The stimulus meets this by moving only one line at a time and holding each level for ten system clocks, which is well above the filter window. The exception is the deliberate glitches: they are shorter than the window, or exactly as long as it, and they are applied only while the other line is steady.

// File: rtl/tw_cond_pkg.sv
package tw_cond_pkg;
  localparam int unsigned N_LINES = 2;
  localparam int unsigned SCL_IDX = 0;
  localparam int unsigned SDA_IDX = 1;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tw_glitch_filter.sv
module tw_glitch_filter #(
  parameter int unsigned FILTER_CYCLES = 5,
  parameter logic        RST_VAL       = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CNT_W = (FILTER_CYCLES > 1) ? $clog2(FILTER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LIM = CNT_W'(FILTER_CYCLES - 1);

  logic [CNT_W-1:0] run_q;
  logic             lvl_q;

  // level moves only after FILTER_CYCLES consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= RST_VAL;
    end else if (d_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q == LIM) begin
      run_q <= '0;
      lvl_q <= d_i;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/tw_event_gen.sv
module tw_event_gen
  import tw_cond_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o,
  output logic     bit_o
);
  logic     scl_q, sda_q;
  bus_evt_t evt_d, evt_q;
  logic     bit_q;

  always_comb begin
    evt_d       = '0;
    evt_d.start = scl_q & scl_i & sda_q & ~sda_i;
    evt_d.stop  = scl_q & scl_i & ~sda_q & sda_i;
    evt_d.rise  = ~scl_q & scl_i;
    evt_d.fall  = scl_q & ~scl_i;
    if (!en_i) evt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      evt_q <= '0;
      bit_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      evt_q <= evt_d;
      if (evt_d.rise) bit_q <= sda_i;
    end
  end

  assign evt_o = evt_q;
  assign bit_o = bit_q;
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect
  import tw_cond_pkg::*;
#(
  parameter int unsigned FILTER_CYCLES = 5,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic bit_o
);
  logic [N_LINES-1:0] raw, sync_q, filt_q;
  bus_evt_t           evt;

  assign raw[SCL_IDX] = scl_i;
  assign raw[SDA_IDX] = sda_i;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    tw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[i]),
      .q_o   (sync_q[i])
    );
    tw_glitch_filter #(.FILTER_CYCLES(FILTER_CYCLES), .RST_VAL(1'b1)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (sync_q[i]),
      .q_o   (filt_q[i])
    );
  end

  tw_event_gen u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .scl_i (filt_q[SCL_IDX]),
    .sda_i (filt_q[SDA_IDX]),
    .evt_o (evt),
    .bit_o (bit_o)
  );

  assign start_o    = evt.start;
  assign stop_o     = evt.stop;
  assign scl_rise_o = evt.rise;
  assign scl_fall_o = evt.fall;
endmodule

// File: rtl/tw_cond_detect_chk.sv
module tw_cond_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_filt,
  input logic sda_filt,
  input logic start_o,
  input logic stop_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic bit_o
);
  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R3
  stop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
  // R4
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_rise_o |-> $stable(bit_o));
  // R7
  gated_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !(start_o || stop_o || scl_rise_o || scl_fall_o));
  // R8
  start_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(scl_filt) && $past(scl_filt, 2) && $past(sda_filt, 2) && !$past(sda_filt)));
  // R8
  stop_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> ($past(scl_filt) && $past(scl_filt, 2) && !$past(sda_filt, 2) && $past(sda_filt)));
  // R9
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));
endmodule

bind tw_cond_detect tw_cond_detect_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .scl_filt  (filt_q[tw_cond_pkg::SCL_IDX]),
  .sda_filt  (filt_q[tw_cond_pkg::SDA_IDX]),
  .start_o   (start_o),
  .stop_o    (stop_o),
  .scl_rise_o(scl_rise_o),
  .scl_fall_o(scl_fall_o),
  .bit_o     (bit_o)
);

// File: tb/tw_cond_detect_tb.sv
module tw_cond_detect_tb;
  localparam int FC = 5;
  localparam int T  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, scl = 1'b1, sda = 1'b1;
  logic start_o, stop_o, rise_o, fall_o, bit_o;

  int n_tests = 0, n_fail = 0;
  int c_start = 0, c_stop = 0, c_rise = 0, c_fall = 0;
  logic [15:0] bits_seen = '0;
  bit done = 0;

  always #10 clk = ~clk;

  tw_cond_detect #(.FILTER_CYCLES(FC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
    .start_o(start_o), .stop_o(stop_o), .scl_rise_o(rise_o),
    .scl_fall_o(fall_o), .bit_o(bit_o)
  );

  // behavioural reference: raw history, run-length filter, previous level
  bit hs[$], hd[$];
  int run_s, run_d;
  bit fs, fd, ps, pd;
  bit m_start, m_stop, m_rise, m_fall, m_bit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs = {1'b1, 1'b1}; hd = {1'b1, 1'b1};
      run_s = 0; run_d = 0;
      fs = 1; fd = 1; ps = 1; pd = 1;
      m_start = 0; m_stop = 0; m_rise = 0; m_fall = 0; m_bit = 0;
    end else begin
      bit vs, vd;
      m_start = en && ps && fs && pd && !fd;
      m_stop  = en && ps && fs && !pd && fd;
      m_rise  = en && !ps && fs;
      m_fall  = en && ps && !fs;
      if (m_rise) m_bit = fd;
      ps = fs; pd = fd;
      vs = hs[1]; vd = hd[1];
      hs.push_front(scl); void'(hs.pop_back());
      hd.push_front(sda); void'(hd.pop_back());
      if (vs == fs) run_s = 0;
      else if (run_s == FC - 1) begin fs = vs; run_s = 0; end
      else run_s++;
      if (vd == fd) run_d = 0;
      else if (run_d == FC - 1) begin fd = vd; run_d = 0; end
      else run_d++;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 start vs model", start_o, m_start);
      check("R3 stop vs model", stop_o, m_stop);
      check("R4 rise vs model", rise_o, m_rise);
      check("R4 bit vs model", bit_o, m_bit);
      check("R5 fall vs model", fall_o, m_fall);
      check("R9 strobe count", $countones({start_o, stop_o, rise_o, fall_o}) <= 1, 1);
      c_start += start_o; c_stop += stop_o; c_fall += fall_o;
      if (rise_o) begin c_rise++; bits_seen = {bits_seen[14:0], bit_o}; end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clr();
    c_start = 0; c_stop = 0; c_rise = 0; c_fall = 0;
  endtask

  task automatic line(logic s, logic d, int n);
    scl = s; sda = d;
    cyc(n);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int lat;
    logic [7:0] pat;
    cyc(3);
    // R1 reset state
    check("R1 start in reset", start_o, 0);
    check("R1 bit in reset", bit_o, 0);
    rst_n = 1'b1;
    cyc(2 * T);
    check("R1 strobes idle", start_o | stop_o | rise_o | fall_o, 0);
    check("R1 bit idle", bit_o, 0);

    // R2/R3/R4/R5 full frame
    pat = 8'hA5;
    clr(); bits_seen = '0;
    line(1, 0, T);
    line(0, 0, T);
    for (int i = 7; i >= 0; i--) begin
      line(0, pat[i], T);
      line(1, pat[i], T);
      line(0, pat[i], T);
    end
    line(0, 0, T);
    line(1, 0, T);
    line(1, 1, 2 * T);
    check("R2 frame starts", c_start, 1);
    check("R3 frame stops", c_stop, 1);
    check("R4 frame rises", c_rise, 9);
    check("R4 frame bits", bits_seen[8:1], pat);
    check("R5 frame falls", c_fall, 9);

    // R6 short glitches rejected
    clr();
    line(1, 0, FC - 1);
    line(1, 1, 2 * T);
    line(0, 1, FC - 1);
    line(1, 1, 2 * T);
    check("R6 short sda glitch start", c_start + c_stop, 0);
    check("R6 short scl glitch", c_rise + c_fall, 0);
    // R6 exact window accepted
    clr();
    line(1, 0, FC);
    line(1, 1, 2 * T);
    check("R6 window start", c_start, 1);
    check("R6 window stop", c_stop, 1);
    // R6 latency
    @(negedge clk);
    sda = 1'b0;
    lat = 0;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk); #1;
      if (start_o && lat == 0) lat = c;
    end
    check("R6 start latency", lat, FC + 3);
    line(1, 1, 2 * T);

    // R7 disabled
    clr();
    en = 1'b0;
    line(1, 0, T);
    line(0, 0, T);
    line(1, 0, T);
    line(1, 1, T);
    line(0, 1, T);
    line(1, 1, T);
    en = 1'b1;
    cyc(2 * T);
    check("R7 gated strobes", c_start + c_stop + c_rise + c_fall, 0);
    // R7 bus changed level while disabled
    en = 1'b0;
    line(0, 1, 2 * T);
    en = 1'b1;
    cyc(2 * T);
    check("R7 no stale fall", c_fall, 0);
    line(1, 1, 2 * T);

    // R8 sda toggles with scl low
    clr();
    line(0, 1, T);
    line(0, 0, T);
    line(0, 1, T);
    line(0, 0, T);
    line(0, 1, T);
    line(1, 1, 2 * T);
    check("R8 no start", c_start, 0);
    check("R8 no stop", c_stop, 0);
    check("R5 single fall", c_fall, 1);
    check("R4 single rise", c_rise, 1);
    check("R4 bit high", bit_o, 1);

    done = 1;
    summary();
  end
endmodule